// File: doc/BRIEF.md
# CVSD Delta Modulation Encoder

This block turns a stream of signed, band-limited PCM samples into a serial stream of one bit per sample, using continuously variable slope delta modulation. A bit-clock enable marks each sampling instant. At that instant the block compares the sample with a locally rebuilt copy of the signal and sends out the sign of the difference. It then moves the local copy up or down by the current step size.

The step size comes from a digital leaky filter. That filter charges whenever the last three output bits were equal and discharges otherwise, so loud or fast-moving input widens the step and quiet input narrows it. The local copy is held in a leaky accumulator, which limits how long a channel bit error can persist. A rate-select input picks the leak shifts so that both time constants stay roughly fixed in time whether the bit rate is 16 kbps or 32 kbps. The run-of-three flag and the current step size are brought out for test.

Top module: `cvsd_enc`

## Requirements
- R1: On each cycle with `bit_en` high, the encoded bit is 1 when `sample_in` (signed) is greater than or equal to the reconstruction value, and 0 otherwise. The reconstruction value is 0 after reset.
- R2: `bit_out` presents the newest encoded bit from the cycle after the enable. `bit_out`, `coinc` and `step_out` change only on the edge of a cycle with `bit_en` high.
- R3: A 3-bit history holds the newest bit and the two before it. On each enable, `coinc` is loaded with 1 only if the three newest bits are all 0 or all 1 and at least three bits have been encoded since reset; otherwise it is loaded with 0.
- R4: On an enable while `coinc` is 1, the step accumulator (`step_out` with 8 fraction bits, `acc`) becomes `acc + ((STEP_MAX*256 - acc) >> S)`.
- R5: On an enable while `coinc` is 0, the step accumulator becomes `acc - ((acc - STEP_MIN*256) >> S)`.
- R6: `step_out` always stays within STEP_MIN to STEP_MAX (defaults 128 and 2048, a 16:1 ratio).
- R7: On each enable, the reconstruction value r becomes `r - (r >>> L) + step_out` when the bit is 1 and `r - (r >>> L) - step_out` when it is 0. The old `step_out` is used.
- R8: The reconstruction value saturates at +32767 and -32768 instead of wrapping.
- R9: `rate_sel` = 0 (16 kbps) selects S=6 and L=4. `rate_sel` = 1 (32 kbps) selects S=7 and L=5.
- R10: A synchronous active-high `rst` clears the history, the bit count, `bit_out`, `coinc` and the reconstruction value, and sets `step_out` to STEP_MIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe per sampling instant |
| rate_sel | input | 1 | 0 = 16 kbps leak shifts, 1 = 32 kbps leak shifts |
| sample_in | input | DW | Signed input sample |
| bit_out | output | 1 | Encoded serial bit |
| coinc | output | 1 | Run-of-three flag for the current bit period |
| step_out | output | DW | Current step size (integer part) |

## Verification
The hardest state to reach is saturation of the reconstruction value, because the leak pulls it back toward zero. At 16 kbps a full-scale input settles just below the limit. The bench therefore selects the 32 kbps leak with a held full-scale input until the step reaches its maximum and the accumulator clamps. It then drops the input slightly: a clamped accumulator must yield a 0 bit, while a wrapped one would yield a 1. The three-bit fill rule after reset is also driven directly, with a negative input that makes the first bits 0 while the cleared history also reads as zeros.

// File: rtl/cvsd_enc.sv
module cvsd_enc #(
  parameter int DW       = 16,
  parameter int FRAC     = 8,
  parameter int STEP_MIN = 128,
  parameter int STEP_MAX = 2048,
  parameter int SYL_SH0  = 6,
  parameter int SYL_SH1  = 7,
  parameter int REC_SH0  = 4,
  parameter int REC_SH1  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 rate_sel,
  input  logic signed [DW-1:0] sample_in,
  output logic                 bit_out,
  output logic                 coinc,
  output logic        [DW-1:0] step_out
);
  localparam int AW = DW + FRAC;
  localparam int XW = DW + 2;
  localparam logic [AW-1:0] ACC_MAX = AW'(STEP_MAX) << FRAC;
  localparam logic [AW-1:0] ACC_MIN = AW'(STEP_MIN) << FRAC;
  localparam logic signed [XW-1:0] POS_FS = XW'((2 ** (DW - 1)) - 1);
  localparam logic signed [XW-1:0] NEG_FS = -XW'(2 ** (DW - 1));

  logic [2:0]           hist;
  logic [1:0]           fill;
  logic [AW-1:0]        acc;
  logic signed [DW-1:0] recon;

  wire cmp = sample_in >= recon;
  wire [2:0] hist_nx = {hist[1:0], cmp};
  wire run3 = (fill == 2'd2) && (hist_nx == 3'b000 || hist_nx == 3'b111);

  wire [4:0] syl_sh = rate_sel ? 5'(SYL_SH1) : 5'(SYL_SH0);
  wire [4:0] rec_sh = rate_sel ? 5'(REC_SH1) : 5'(REC_SH0);

  wire [AW-1:0] gap_up = ACC_MAX - acc;
  wire [AW-1:0] gap_dn = acc - ACC_MIN;
  wire [AW-1:0] acc_nx = coinc ? acc + (gap_up >> syl_sh) : acc - (gap_dn >> syl_sh);

  wire signed [XW-1:0] r_ext = XW'(recon);
  wire signed [XW-1:0] r_leak = r_ext >>> rec_sh;
  wire signed [XW-1:0] st_ext = $signed({2'b00, step_out});
  wire signed [XW-1:0] r_sum = r_ext - r_leak + (cmp ? st_ext : -st_ext);
  wire signed [XW-1:0] r_sat = (r_sum > POS_FS) ? POS_FS : (r_sum < NEG_FS) ? NEG_FS : r_sum;

  assign step_out = acc[AW-1:FRAC];
  assign bit_out  = hist[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= 3'b000;
      fill  <= 2'd0;
      coinc <= 1'b0;
      acc   <= ACC_MIN;
      recon <= '0;
    end else if (bit_en) begin
      hist  <= hist_nx;
      fill  <= (fill == 2'd2) ? fill : fill + 2'd1;
      coinc <= run3;
      acc   <= acc_nx;
      recon <= r_sat[DW-1:0];
    end
  end
endmodule

// File: rtl/cvsd_enc_chk.sv
module cvsd_enc_chk #(
  parameter int DW       = 16,
  parameter int STEP_MIN = 128,
  parameter int STEP_MAX = 2048
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          bit_out,
  input logic          coinc,
  input logic [DW-1:0] step_out,
  input logic [2:0]    hist
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  assert_step_range_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(step_out) >= STEP_MIN) && (int'(step_out) <= STEP_MAX));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(bit_out) && $stable(coinc) && $stable(step_out));

  assert_charge_up_R4: assert property (@(posedge clk) disable iff (rst)
    bit_en && coinc |=> step_out >= $past(step_out));

  assert_discharge_dn_R5: assert property (@(posedge clk) disable iff (rst)
    bit_en && !coinc |=> step_out <= $past(step_out));

  assert_run_equal_R3: assert property (@(posedge clk) disable iff (rst)
    coinc |-> (hist == 3'b000 || hist == 3'b111));

  always_ff @(posedge clk) begin
    if (was_rst && !rst)
      assert_reset_state_R10: assert (!bit_out && !coinc && int'(step_out) == STEP_MIN);
  end
endmodule

bind cvsd_enc cvsd_enc_chk #(.DW(DW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .bit_out(bit_out),
  .coinc(coinc), .step_out(step_out), .hist(hist)
);

// File: tb/cvsd_enc_tb.sv
module cvsd_enc_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic rate_sel = 1'b0;
  logic signed [15:0] sample_in = '0;
  logic bit_out, coinc;
  logic [15:0] step_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_hist, m_cnt, m_coinc, m_acc, m_recon;

  always #10 clk = ~clk;

  cvsd_enc u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rate_sel(rate_sel),
    .sample_in(sample_in), .bit_out(bit_out), .coinc(coinc), .step_out(step_out)
  );

  // {rate, bit count, sample}
  localparam int NSEG = 8;
  localparam logic [32:0] SEG [NSEG] = '{
    {1'b0, 16'd20,  16'sd0},
    {1'b0, 16'd200, 16'sd20000},
    {1'b0, 16'd200, -16'sd20000},
    {1'b0, 16'd400, 16'sd0},
    {1'b1, 16'd300, 16'sd5000},
    {1'b1, 16'd600, 16'sd32767},
    {1'b1, 16'd5,   16'sd32000},
    {1'b1, 16'd600, -16'sd32768}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_hist = 0; m_cnt = 0; m_coinc = 0; m_acc = 128 * 256; m_recon = 0;
  endtask

  task automatic m_update(input int s, input int rate);
    int cmp, nh, ssh, rsh, st, r;
    cmp = (s >= m_recon) ? 1 : 0;
    nh  = ((m_hist << 1) | cmp) & 7;
    ssh = rate ? 7 : 6;
    rsh = rate ? 5 : 4;
    st  = m_acc >> 8;
    r   = m_recon - (m_recon >>> rsh) + (cmp ? st : -st);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    if (m_coinc) m_acc = m_acc + ((2048 * 256 - m_acc) >> ssh);
    else         m_acc = m_acc - ((m_acc - 128 * 256) >> ssh);
    m_coinc = (m_cnt == 2 && (nh == 0 || nh == 7)) ? 1 : 0;
    m_cnt   = (m_cnt == 2) ? 2 : m_cnt + 1;
    m_hist  = nh;
    m_recon = r;
  endtask

  task automatic do_bit(input int s, input int rate);
    logic b0, c0;
    logic [15:0] st0;
    @(negedge clk);
    rate_sel = rate[0];
    sample_in = 16'(s);
    bit_en = 1'b1;
    m_update(s, rate);
    @(negedge clk);
    bit_en = 1'b0;
    check("R1 bit", int'(bit_out), m_hist & 1);
    check("R3 coinc", int'(coinc), m_coinc);
    check(rate ? "R9/R4/R5 step 32k" : "R9/R4/R5 step 16k", int'(step_out), m_acc >> 8);
    check("R6 step range", int'(step_out >= 16'd128 && step_out <= 16'd2048), 1);
    b0 = bit_out; c0 = coinc; st0 = step_out;
    sample_in = 16'(-s);
    @(negedge clk);
    check("R2 idle hold", int'({b0, c0, st0} == {bit_out, coinc, step_out}), 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
  endtask

  initial begin
    m_reset();
    do_reset();
    check("R10 reset bit", int'(bit_out), 0);
    check("R10 reset coinc", int'(coinc), 0);
    check("R10 reset step", int'(step_out), 128);

    for (int i = 0; i < NSEG; i++) begin
      for (int k = 0; k < int'(SEG[i][31:16]); k++)
        do_bit(int'($signed(SEG[i][15:0])), int'(SEG[i][32]));
      if (i == 5) check("R8 clamp at +FS", m_recon, 32767);
      if (i == 6) check("R8 saturated bit", int'(bit_out), 0);
    end

    // triangle wave at 16 kbps, R7 tracking
    for (int k = 0; k < 512; k++) begin
      int ph;
      ph = k % 64;
      do_bit((ph < 32) ? (-8000 + ph * 500) : (8000 - (ph - 32) * 500), 0);
    end

    // reset in the middle of activity, then the fill rule
    do_reset();
    check("R10 mid reset step", int'(step_out), 128);
    check("R10 mid reset coinc", int'(coinc), 0);
    do_bit(-30000, 0);
    check("R3 no flag after first bit", int'(coinc), 0);
    check("R1 first bit zero", int'(bit_out), 0);
    do_bit(-30000, 0);
    check("R3 no flag after second bit", int'(coinc), 0);
    do_bit(-30000, 0);
    check("R3 flag after third equal bit", int'(coinc), 1);
    do_bit(-30000, 0);
    check("R4 step grows on flag", int'(step_out > 16'd128), 1);

    // R7: 16 kbps from reset, zero input alternates
    do_reset();
    do_bit(0, 0);
    check("R7 first bit one", int'(bit_out), 1);
    do_bit(0, 0);
    check("R7 recon 128 gives zero", int'(bit_out), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule